// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic-logic stage of a small 8-bit RISC core. In one clock cycle it combines an operand pair (opb may be a register value or an immediate; the block does not care which) under a 4-bit operation code. It drives the result combinationally and, on the clock edge where `op_en` is high, writes a six-bit status register: carry, zero, negative, overflow, sign and half-carry. The stored carry and zero bits feed back into the next operation. This lets multi-byte additions, subtractions and compares chain across bytes.

Each operation writes only its own subset of flags and leaves the others alone. The sign flag always equals negative XOR overflow, so a signed "less than" can be read straight from it. Subtract-with-carry can clear the zero flag but can never set it. A chain of byte compares therefore reports zero only when every byte matched.

Top module: `alu8_core`

## Requirements
- R1: After reset, `flags` is 0. Bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: ADD (code 0) gives a+b, and ADC (code 1) gives a+b+C. Both write C (carry out of bit 7), Z, N, V (signed overflow) and H (carry out of bit 3).
- R3: SUB (code 2) gives a-b, and SBC (code 3) gives a-b-C. Both write C (borrow out of bit 7), N, V and H (borrow out of bit 3). SUB writes Z as result==0.
- R4: For SBC, the new Z is 1 only when the result is 0 and Z was already 1. A nonzero result clears Z.
- R5: AND (4), OR (5) and XOR (6) write Z and N, and force V to 0. C and H are unchanged.
- R6: COM (7) gives 0xFF-a, sets C to 1 and V to 0, and leaves H unchanged. NEG (8) gives 0x00-a and writes C, Z, N, V and H with subtraction meaning.
- R7: INC (9) and DEC (10) write Z, N and V. V is set when the result is 0x80 for INC, or 0x7F for DEC. C and H are unchanged.
- R8: LSR (11), ASR (12), ROR (13) and ROL (14) shift by one place. For LSR, bit 7 becomes 0. For ASR, bit 7 is kept. For ROR, the old C goes into bit 7. For ROL, the old C goes into bit 0. C receives the bit shifted out, V = N XOR C, and H is unchanged.
- R9: SWAP (15) exchanges the two nibbles and leaves every flag unchanged.
- R10: After any operation that writes flags, S equals N XOR V.
- R11: While `op_en` is low, `flags` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Commit the flag update this cycle |
| op_code | input | 4 | Operation select (codes in R2 to R9) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand or immediate |
| result | output | 8 | Combinational result |
| flags | output | 6 | Status register {H,S,V,N,Z,C} |

## Verification
The hardest state to reach from the ports is the sticky zero flag: an SBC whose result is zero while Z is already 0. Reaching it takes a prior nonzero step in a subtract chain. A directed sequence builds compare chains in which Z is first set, then kept, then cleared, and then held clear by a zero result. A sweep of every opcode over all 256 values of `opa` runs the operations back to back. The stored carry and zero bits therefore enter each step in both states, and the bench tracks its own model of the status register.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR, OP_COM,
    OP_NEG, OP_INC, OP_DEC, OP_LSR, OP_ASR, OP_ROR, OP_ROL, OP_SWAP
  } alu_op_e;

  // Which status bits an operation is allowed to write.
  function automatic logic [NFLAG-1:0] upd_mask(alu_op_e op);
    logic [NFLAG-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
        m = '1;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        m[FZ] = 1'b1; m[FN] = 1'b1; m[FV] = 1'b1; m[FS] = 1'b1;
      end
      OP_COM, OP_LSR, OP_ASR, OP_ROR, OP_ROL: begin
        m[FC] = 1'b1; m[FZ] = 1'b1; m[FN] = 1'b1; m[FV] = 1'b1; m[FS] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic uses_adder(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC};
  endfunction

  function automatic logic is_shift(alu_op_e op);
    return op inside {OP_LSR, OP_ASR, OP_ROR, OP_ROL};
  endfunction

  // Carry (add) or borrow (sub) out of a bit position, rebuilt from the
  // operand bits and the sum bit at that position.
  function automatic logic carry_at(logic a, logic b, logic r, logic sub);
    if (sub) return (~a & b) | (b & r) | (r & ~a);
    else     return (a & b) | (b & ~r) | (~r & a);
  endfunction

  function automatic logic ovf_at(logic a, logic b, logic r, logic sub);
    if (sub) return (a != b) && (r != a);
    else     return (a == b) && (r != a);
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W/2 - 1;

  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  assign r     = ext[W-1:0];
  assign c_out = ext[W];
  assign h_out = carry_at(a[HB], b[HB], r[HB], sub);
  assign v_out = ovf_at(a[W-1], b[W-1], r[W-1], sub);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         c_out
);
  localparam int HALF = W/2;

  always_comb begin
    r     = '0;
    c_out = 1'b0;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  begin r = ~a; c_out = 1'b1; end
      OP_LSR:  begin r = {1'b0, a[W-1:1]};   c_out = a[0];   end
      OP_ASR:  begin r = {a[W-1], a[W-1:1]}; c_out = a[0];   end
      OP_ROR:  begin r = {cin, a[W-1:1]};    c_out = a[0];   end
      OP_ROL:  begin r = {a[W-2:0], cin};    c_out = a[W-1]; end
      OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NFLAG-1:0] mask,
  input  logic [NFLAG-1:0] nxt,
  output logic [NFLAG-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= (mask & nxt) | (~mask & q);
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  for (genvar i = 0; i < NFLAG; i++) begin : g_keep
    // R5 R7 R9: a bit outside the write mask is left alone
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !mask[i]) |=> $stable(q[i]));
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic [5:0]   flags
);
  alu_op_e op;
  assign op = alu_op_e'(op_code);

  // Adder operand steering
  logic [W-1:0] add_a, add_b, add_r, bit_r;
  logic         add_cin, add_sub, add_c, add_h, add_v, bit_c;

  always_comb begin
    add_a   = opa;
    add_b   = opb;
    add_cin = 1'b0;
    add_sub = 1'b0;
    case (op)
      OP_ADC: add_cin = flags[FC];
      OP_SUB: add_sub = 1'b1;
      OP_SBC: begin add_sub = 1'b1; add_cin = flags[FC]; end
      OP_NEG: begin add_sub = 1'b1; add_a = '0; add_b = opa; end
      OP_INC: add_b = W'(1);
      OP_DEC: begin add_sub = 1'b1; add_b = W'(1); end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(add_a), .b(add_b), .cin(add_cin), .sub(add_sub),
    .r(add_r), .c_out(add_c), .h_out(add_h), .v_out(add_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op(op), .a(opa), .b(opb), .cin(flags[FC]), .r(bit_r), .c_out(bit_c)
  );

  // Named internal events for the checks below
  logic sel_adder, res_zero, chain_zero;
  logic new_c, new_n, new_v;
  logic [NFLAG-1:0] nxt_flags, wr_mask;

  assign sel_adder  = uses_adder(op);
  assign result     = sel_adder ? add_r : bit_r;
  assign res_zero   = (result == '0);
  assign chain_zero = res_zero & flags[FZ];
  assign new_n      = result[W-1];
  assign new_c      = sel_adder ? add_c : bit_c;

  always_comb begin
    if (sel_adder)     new_v = add_v;
    else if (is_shift(op)) new_v = new_n ^ new_c;
    else               new_v = 1'b0;
  end

  always_comb begin
    nxt_flags     = '0;
    nxt_flags[FC] = new_c;
    nxt_flags[FZ] = (op == OP_SBC) ? chain_zero : res_zero;
    nxt_flags[FN] = new_n;
    nxt_flags[FV] = new_v;
    nxt_flags[FS] = new_n ^ new_v;
    nxt_flags[FH] = add_h;
  end

  assign wr_mask = upd_mask(op);

  alu8_status u_status (
    .clk(clk), .rst_n(rst_n), .en(op_en),
    .mask(wr_mask), .nxt(nxt_flags), .q(flags)
  );

  // R4
  sbc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_SBC && !flags[FZ]) |=> !flags[FZ]);

  // R5
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op inside {OP_AND, OP_OR, OP_XOR}) |=> !flags[FV]);

  // R6
  com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_COM) |=> (flags[FC] && !flags[FV]));

  // R9
  swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_SWAP) |=> $stable(flags));

  // R10
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && wr_mask[FS]) |=> (flags[FS] == (flags[FN] ^ flags[FV])));

  // R8
  shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && is_shift(op)) |=> (flags[FV] == (flags[FN] ^ flags[FC])));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] opa = 8'd0, opb = 8'd0;
  logic [7:0] result;
  logic [5:0] flags;

  int total = 0;
  int bad = 0;
  logic [5:0] mflags;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .opa(opa), .opb(opb), .result(result), .flags(flags)
  );

  // Reference: {new flags, result}, flags packed {H,S,V,N,Z,C}
  function automatic logic [13:0] ref_calc(int op, int a, int b, logic [5:0] f);
    int r, sa, sb, sv, ci, k;
    logic c, z, n, v, h;
    c = f[0]; v = f[3]; h = f[5];
    ci = f[0] ? 1 : 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    r = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? ci : 0;
        r = a + b + k; c = (r > 255);
        h = ((a % 16) + (b % 16) + k) > 15;
        sv = sa + sb + k; v = (sv > 127) || (sv < -128);
      end
      2, 3: begin
        k = (op == 3) ? ci : 0;
        r = a - b - k; c = (r < 0);
        h = (a % 16) < ((b % 16) + k);
        sv = sa - sb - k; v = (sv > 127) || (sv < -128);
      end
      4: begin r = a & b; v = 1'b0; end
      5: begin r = a | b; v = 1'b0; end
      6: begin r = a ^ b; v = 1'b0; end
      7: begin r = 255 - a; c = 1'b1; v = 1'b0; end
      8: begin r = 0 - a; c = (a != 0); h = (a % 16) != 0; v = (a == 128); end
      9: begin r = a + 1; v = (a == 127); end
      10: begin r = a - 1; v = (a == 128); end
      11: begin r = a / 2; c = a[0]; end
      12: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a[0]; end
      13: begin r = a / 2 + ci * 128; c = a[0]; end
      14: begin r = (a * 2) % 256 + ci; c = (a >= 128); end
      default: r = (a % 16) * 16 + a / 16;
    endcase
    r = r & 255;
    n = (r >= 128);
    z = (r == 0);
    if (op == 3) z = z & f[1];
    if (op >= 11 && op <= 14) v = n ^ c;
    if (op == 15) return {f, r[7:0]};
    return {h, n ^ v, v, n, z, c, r[7:0]};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      15: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, check result, then flags after the rise
  task automatic run_op(int op, int a, int b, string req);
    logic [13:0] e;
    @(negedge clk);
    op_en = 1'b1; op_code = op[3:0]; opa = a[7:0]; opb = b[7:0];
    e = ref_calc(op, a, b, mflags);
    #1;
    check(req, "result", int'(result), int'(e[7:0]));
    @(posedge clk);
    #1;
    check(req, "flags", int'(flags), int'(e[13:8]));
    if (flags[5:0] != e[13:8] || 1'b1) mflags = e[13:8];
    if (op != 15) check("R10", "S vs N^V", int'(flags[4]), int'(flags[2] ^ flags[3]));
  endtask

  initial begin
    mflags = 6'd0;
    #7;
    check("R1", "reset flags", int'(flags), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: sticky zero through a compare chain
    run_op(2, 8'h12, 8'h12, "R3");   // Z=1, C=0
    run_op(3, 8'h34, 8'h34, "R4");   // zero result, Z kept at 1
    check("R4", "Z kept", int'(flags[1]), 1);
    run_op(3, 8'h01, 8'h00, "R4");   // nonzero clears Z
    check("R4", "Z cleared", int'(flags[1]), 0);
    run_op(3, 8'h00, 8'h00, "R4");   // zero result but Z stays 0
    check("R4", "Z stays clear", int'(flags[1]), 0);
    run_op(2, 8'h00, 8'h01, "R3");   // borrow sets C
    run_op(3, 8'h01, 8'h00, "R4");   // 1-0-1 = 0, Z was 0 -> 0
    check("R4", "carry chain zero", int'(flags[1]), 0);

    // Boundary cases
    run_op(0, 8'h7F, 8'h01, "R2");
    run_op(0, 8'hFF, 8'h01, "R2");
    run_op(8, 8'h80, 8'h00, "R6");
    run_op(8, 8'h00, 8'h00, "R6");
    run_op(9, 8'h7F, 8'h00, "R7");
    run_op(10, 8'h80, 8'h00, "R7");
    run_op(7, 8'h00, 8'h00, "R6");
    run_op(15, 8'hA5, 8'h00, "R9");

    // R11: op_en low, inputs move, flags hold
    begin
      logic [5:0] held;
      @(negedge clk);
      held = flags;
      op_en = 1'b0; op_code = 4'd0; opa = 8'hFF; opb = 8'hFF;
      @(posedge clk); #1;
      op_code = 4'd2; opa = 8'h00; opb = 8'h01;
      @(posedge clk); #1;
      check("R11", "idle hold", int'(flags), int'(held));
    end

    // Sweep every opcode over all first operands
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          run_op(op, a, (j * 17 + a * 3) & 255, tag_of(op));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule